// File: doc/BRIEF.md
# Serial Port Interrupt and Line Status Controller

This block holds the interrupt and status logic of a serial port that has 16-entry receive and transmit queues. It does not hold the queues, the shift registers or the bit-rate timer. It watches how full each queue is, the error flags that come with each received character, and a timeout request from the receive side. From these it forms three interrupt sources. A fixed priority ranks them into a four-bit identification code, and a single interrupt line is raised from that code.

Software writes an enable register and a queue-control register through write strobes. It also reports the identification-register reads, line-status reads and transmit-holding writes it performs. For polled operation the block presents line-status bits: receive data ready, transmit queue empty, and four sticky error flags. With every interrupt source disabled, software can run the port from these bits alone.

Top module: `sio_irq_ctrl`

## Requirements
- R1: After reset, `irq` is 0 and `iir_code` is 4'b0001. `lsr_err` is 0, `lsr_rx_ready` is 0, `lsr_tx_empty` is 1, and all interrupt enables are off.
- R2: `fcr_rx_sel`, captured on `fcr_wr`, selects the receive trigger level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 entries. The receive request is active while `rx_count` is at or above the level and inactive below it.
- R3: With receive enable `ier_wdata[0]` set, an active receive request shows code 4'b0100 one cycle after `rx_count` changes.
- R4: Line status ranks highest, with code 4'b0110. It is active while line-status enable `ier_wdata[2]` is set and any sticky error bit is set. It is shown one cycle after the error bit is stored.
- R5: The timeout request `rx_timeout` is gated by the receive enable and shows code 4'b1100. It shares the receive level. When both are active, 4'b0100 is shown.
- R6: Transmitter-empty, with code 4'b0010, ranks lowest and is gated by `ier_wdata[1]`. Its pending flag is set when `tx_count` goes from nonzero to 0, or when an enable write sets `ier_wdata[1]` while `tx_count` is 0.
- R7: A `thr_wr` clears the transmitter-empty pending flag, and this clear wins over any set in the same cycle.
- R8: An `iir_rd` clears the transmitter-empty pending flag only while `iir_code` shows 4'b0010. A read while any other code shows leaves the flag set.
- R9: With all three enables off, `iir_code` stays 4'b0001 and `irq` stays 0 whatever the queue, error and timeout inputs do.
- R10: One cycle after the counts change, `lsr_rx_ready` equals (`rx_count` != 0) and `lsr_tx_empty` equals (`tx_count` == 0).
- R11: `lsr_err` (bit0 overrun, bit1 parity, bit2 framing, bit3 break) accumulates `rx_err` pulses and holds them. An `lsr_rd` clears the stored bits, but bits arriving in the same cycle as the read are kept.
- R12: `irq` is 1 exactly when `iir_code` is not 4'b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 3 | Enables: bit0 receive/timeout, bit1 transmitter-empty, bit2 line status |
| fcr_wr | input | 1 | Queue control write strobe |
| fcr_rx_sel | input | 2 | Receive trigger level select |
| iir_rd | input | 1 | Software read of the identification code |
| lsr_rd | input | 1 | Software read of the line status |
| thr_wr | input | 1 | Software write of a character into the transmit queue |
| rx_count | input | CNT_W | Receive queue occupancy |
| tx_count | input | CNT_W | Transmit queue occupancy |
| rx_err | input | 4 | Error flags pulsed with a received character |
| rx_timeout | input | 1 | Receive timeout request |
| irq | output | 1 | Interrupt line |
| iir_code | output | 4 | Identification code of the highest pending source |
| lsr_rx_ready | output | 1 | Receive queue not empty |
| lsr_tx_empty | output | 1 | Transmit queue empty |
| lsr_err | output | 4 | Sticky receive error flags |

## Verification
Changes in the occupancy and timeout inputs reach `iir_code`, `irq` and the ready/empty bits after one clock edge. Error pulses and software strobes pass through one more register, the sticky flags, the pending flag or the enable register, so their effect on the code appears after two edges. The bench drives inputs and samples outputs 1 ns after a rising edge. It then waits exactly the one or two edges that each path needs before comparing, so that latency errors are caught as well as wrong values. Priority overlaps, the same-cycle read-and-error case and the code-dependent clear are each driven as separate directed steps.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

  typedef enum logic [3:0] {
    IIR_NONE = 4'b0001,
    IIR_TXE  = 4'b0010,
    IIR_RXD  = 4'b0100,
    IIR_LINE = 4'b0110,
    IIR_TMO  = 4'b1100
  } iir_code_e;

  localparam int ERR_W = 4;

endpackage

// File: rtl/sio_rx_thresh.sv
module sio_rx_thresh #(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fcr_wr,
  input  logic [1:0]       fcr_rx_sel,
  input  logic [CNT_W-1:0] rx_count,
  output logic             rda_req
);

  localparam logic [CNT_W-1:0] LVL0 = CNT_W'(1);
  localparam logic [CNT_W-1:0] LVL1 = CNT_W'(FIFO_DEPTH / 4);
  localparam logic [CNT_W-1:0] LVL2 = CNT_W'(FIFO_DEPTH / 2);
  localparam logic [CNT_W-1:0] LVL3 = CNT_W'(FIFO_DEPTH - 2);

  logic [1:0]       sel_q;
  logic [CNT_W-1:0] level;

  always_ff @(posedge clk) begin
    if (rst)         sel_q <= 2'b00;
    else if (fcr_wr) sel_q <= fcr_rx_sel;
  end

  always_comb begin
    unique case (sel_q)
      2'b00:   level = LVL0;
      2'b01:   level = LVL1;
      2'b10:   level = LVL2;
      default: level = LVL3;
    endcase
  end

  assign rda_req = (rx_count >= level);

  // R2: a one-entry queue never meets any level other than the lowest
  assert_single_entry_level_R2: assert property (@(posedge clk) disable iff (rst)
    (rx_count == CNT_W'(1) && sel_q != 2'b00) |-> !rda_req);

endmodule

// File: rtl/sio_lsr_track.sv
module sio_lsr_track #(
  parameter int CNT_W = 5,
  parameter int ERR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [ERR_W-1:0] rx_err,
  input  logic             lsr_rd,
  output logic             lsr_rx_ready,
  output logic             lsr_tx_empty,
  output logic [ERR_W-1:0] lsr_err
);

  logic [ERR_W-1:0] err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lsr_rx_ready <= 1'b0;
      lsr_tx_empty <= 1'b1;
      err_q        <= '0;
    end else begin
      lsr_rx_ready <= (rx_count != '0);
      lsr_tx_empty <= (tx_count == '0);
      if (lsr_rd) err_q <= rx_err;
      else        err_q <= err_q | rx_err;
    end
  end

  assign lsr_err = err_q;

  // R11: without a status read no stored error bit is lost
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    !lsr_rd |=> ((err_q & $past(err_q)) == $past(err_q)));

  // R10: a non-empty receive queue is reported on the next cycle
  assert_rx_ready_R10: assert property (@(posedge clk) disable iff (rst)
    (rx_count != '0) |=> lsr_rx_ready);

endmodule

// File: rtl/sio_thre_track.sv
module sio_thre_track #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             tx_en_write,
  input  logic             thr_wr,
  input  logic             iir_rd,
  input  logic             iir_shows_txe,
  output logic             txe_pend
);

  logic empty_now;
  logic empty_prev;
  logic set_pend;
  logic clr_pend;

  assign empty_now = (tx_count == '0);
  assign set_pend  = (empty_now && !empty_prev) || (tx_en_write && empty_now);
  assign clr_pend  = thr_wr || (iir_rd && iir_shows_txe);

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_prev <= 1'b1;
      txe_pend   <= 1'b0;
    end else begin
      empty_prev <= empty_now;
      if (clr_pend)      txe_pend <= 1'b0;
      else if (set_pend) txe_pend <= 1'b1;
    end
  end

  // R7: writing a character always drops the pending flag
  assert_thr_write_clears_R7: assert property (@(posedge clk) disable iff (rst)
    thr_wr |=> !txe_pend);

  // R8: reading the code while another source shows keeps the flag
  assert_foreign_read_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    (iir_rd && !iir_shows_txe && !thr_wr && txe_pend) |=> txe_pend);

endmodule

// File: rtl/sio_irq_prio.sv
module sio_irq_prio
  import sio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en_rx,
  input  logic       en_tx,
  input  logic       en_ls,
  input  logic       ls_active,
  input  logic       rda_req,
  input  logic       tmo_req,
  input  logic       txe_pend,
  output logic [3:0] iir_code,
  output logic       irq
);

  iir_code_e next_code;
  iir_code_e code_q;

  always_comb begin
    if (en_ls && ls_active)     next_code = IIR_LINE;
    else if (en_rx && rda_req)  next_code = IIR_RXD;
    else if (en_rx && tmo_req)  next_code = IIR_TMO;
    else if (en_tx && txe_pend) next_code = IIR_TXE;
    else                        next_code = IIR_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= IIR_NONE;
      irq    <= 1'b0;
    end else begin
      code_q <= next_code;
      irq    <= (next_code != IIR_NONE);
    end
  end

  assign iir_code = code_q;

  // R4: an enabled line-status source outranks every other source
  assert_line_first_R4: assert property (@(posedge clk) disable iff (rst)
    (en_ls && ls_active) |=> (code_q == IIR_LINE));

  // R9: with every enable off the code stays idle
  assert_polled_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (!en_rx && !en_tx && !en_ls) |=> (code_q == IIR_NONE && !irq));

  // R5: timeout shown when it is the only active source at its level
  assert_timeout_code_R5: assert property (@(posedge clk) disable iff (rst)
    (en_rx && tmo_req && !rda_req && !(en_ls && ls_active)) |=> (code_q == IIR_TMO));

endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
  import sio_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ier_wr,
  input  logic [2:0]       ier_wdata,
  input  logic             fcr_wr,
  input  logic [1:0]       fcr_rx_sel,
  input  logic             iir_rd,
  input  logic             lsr_rd,
  input  logic             thr_wr,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [3:0]       rx_err,
  input  logic             rx_timeout,
  output logic             irq,
  output logic [3:0]       iir_code,
  output logic             lsr_rx_ready,
  output logic             lsr_tx_empty,
  output logic [3:0]       lsr_err
);

  logic en_rx, en_tx, en_ls;
  logic rda_req;
  logic txe_pend;
  logic [ERR_W-1:0] err_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_rx <= 1'b0;
      en_tx <= 1'b0;
      en_ls <= 1'b0;
    end else if (ier_wr) begin
      en_rx <= ier_wdata[0];
      en_tx <= ier_wdata[1];
      en_ls <= ier_wdata[2];
    end
  end

  sio_rx_thresh #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_thresh (
    .clk        (clk),
    .rst        (rst),
    .fcr_wr     (fcr_wr),
    .fcr_rx_sel (fcr_rx_sel),
    .rx_count   (rx_count),
    .rda_req    (rda_req)
  );

  sio_lsr_track #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_lsr (
    .clk          (clk),
    .rst          (rst),
    .rx_count     (rx_count),
    .tx_count     (tx_count),
    .rx_err       (rx_err),
    .lsr_rd       (lsr_rd),
    .lsr_rx_ready (lsr_rx_ready),
    .lsr_tx_empty (lsr_tx_empty),
    .lsr_err      (err_bits)
  );

  sio_thre_track #(.CNT_W(CNT_W)) u_thre (
    .clk           (clk),
    .rst           (rst),
    .tx_count      (tx_count),
    .tx_en_write   (ier_wr && ier_wdata[1]),
    .thr_wr        (thr_wr),
    .iir_rd        (iir_rd),
    .iir_shows_txe (iir_code == IIR_TXE),
    .txe_pend      (txe_pend)
  );

  sio_irq_prio u_prio (
    .clk       (clk),
    .rst       (rst),
    .en_rx     (en_rx),
    .en_tx     (en_tx),
    .en_ls     (en_ls),
    .ls_active (|err_bits),
    .rda_req   (rda_req),
    .tmo_req   (rx_timeout),
    .txe_pend  (txe_pend),
    .iir_code  (iir_code),
    .irq       (irq)
  );

  assign lsr_err = err_bits;

  // R12: the interrupt line follows the code at the ports
  assert_irq_follows_code_R12: assert property (@(posedge clk) disable iff (rst)
    irq == (iir_code != 4'b0001));

endmodule

// File: tb/sio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module sio_irq_ctrl_bench;

  localparam int CNT_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ier_wr = 0, fcr_wr = 0, iir_rd = 0, lsr_rd = 0, thr_wr = 0, rx_timeout = 0;
  logic [2:0] ier_wdata = '0;
  logic [1:0] fcr_rx_sel = '0;
  logic [CNT_W-1:0] rx_count = '0, tx_count = '0;
  logic [3:0] rx_err = '0;
  logic irq, lsr_rx_ready, lsr_tx_empty;
  logic [3:0] iir_code, lsr_err;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sio_irq_ctrl #(.FIFO_DEPTH(16)) u_sio_irq_ctrl (
    .clk(clk), .rst(rst), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .fcr_wr(fcr_wr), .fcr_rx_sel(fcr_rx_sel), .iir_rd(iir_rd), .lsr_rd(lsr_rd),
    .thr_wr(thr_wr), .rx_count(rx_count), .tx_count(tx_count), .rx_err(rx_err),
    .rx_timeout(rx_timeout), .irq(irq), .iir_code(iir_code),
    .lsr_rx_ready(lsr_rx_ready), .lsr_tx_empty(lsr_tx_empty), .lsr_err(lsr_err)
  );

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_ier(input logic [2:0] v);
    ier_wdata = v; ier_wr = 1; cyc(1); ier_wr = 0;
  endtask

  task automatic write_fcr(input logic [1:0] v);
    fcr_rx_sel = v; fcr_wr = 1; cyc(1); fcr_wr = 0;
  endtask

  task automatic t_reset;
    chk("R1 iir", {4'h0, iir_code}, 8'h01);
    chk("R1 irq", {7'h0, irq}, 8'h00);
    chk("R1 err", {4'h0, lsr_err}, 8'h00);
    chk("R1 ready/empty", {6'h0, lsr_rx_ready, lsr_tx_empty}, 8'h01);
  endtask

  task automatic t_threshold;
    int lv [4] = '{1, 4, 8, 14};
    write_ier(3'b001);
    for (int s = 0; s < 4; s++) begin
      write_fcr(2'(s));
      rx_count = CNT_W'(lv[s] - 1); cyc(2);
      chk("R2 below level", {4'h0, iir_code}, 8'h01);
      rx_count = CNT_W'(lv[s]); cyc(1);
      chk("R3 at level code", {4'h0, iir_code}, 8'h04);
      chk("R12 irq raised", {7'h0, irq}, 8'h01);
      rx_count = CNT_W'(lv[s] - 1); cyc(1);
      chk("R2 drop below", {4'h0, iir_code}, 8'h01);
    end
    rx_count = 16; cyc(1);
    chk("R2 full queue", {4'h0, iir_code}, 8'h04);
    rx_count = 0; cyc(2);
  endtask

  task automatic t_line_status;
    write_ier(3'b101); write_fcr(2'b00);
    rx_count = 1; cyc(2);
    chk("R3 base", {4'h0, iir_code}, 8'h04);
    rx_err = 4'b0100; cyc(1); rx_err = 0;
    chk("R11 stored", {4'h0, lsr_err}, 8'h04);
    cyc(1);
    chk("R4 line first", {4'h0, iir_code}, 8'h06);
    cyc(4);
    chk("R11 held", {4'h0, lsr_err}, 8'h04);
    lsr_rd = 1; rx_err = 4'b0001; cyc(1); lsr_rd = 0; rx_err = 0;
    chk("R11 read with new error", {4'h0, lsr_err}, 8'h01);
    lsr_rd = 1; cyc(1); lsr_rd = 0;
    chk("R11 read clears", {4'h0, lsr_err}, 8'h00);
    cyc(1);
    chk("R4 falls back", {4'h0, iir_code}, 8'h04);
    rx_count = 0; cyc(2);
  endtask

  task automatic t_timeout;
    write_ier(3'b001); write_fcr(2'b10);
    rx_count = 1; rx_timeout = 1; cyc(1);
    chk("R5 timeout code", {4'h0, iir_code}, 8'h0c);
    rx_count = 8; cyc(1);
    chk("R5 receive wins level", {4'h0, iir_code}, 8'h04);
    rx_count = 1; cyc(1);
    chk("R5 timeout again", {4'h0, iir_code}, 8'h0c);
    rx_timeout = 0; cyc(1);
    chk("R5 timeout gone", {4'h0, iir_code}, 8'h01);
    rx_count = 0; cyc(2);
  endtask

  task automatic t_thre;
    write_ier(3'b010); cyc(1);
    chk("R6 enable while empty", {4'h0, iir_code}, 8'h02);
    chk("R12 irq", {7'h0, irq}, 8'h01);
    iir_rd = 1; cyc(1); iir_rd = 0; cyc(1);
    chk("R8 read clears", {4'h0, iir_code}, 8'h01);
    tx_count = 3; cyc(2);
    chk("R6 not empty", {4'h0, iir_code}, 8'h01);
    tx_count = 0; cyc(2);
    chk("R6 became empty", {4'h0, iir_code}, 8'h02);
    thr_wr = 1; tx_count = 1; cyc(1); thr_wr = 0; cyc(1);
    chk("R7 write clears", {4'h0, iir_code}, 8'h01);
    tx_count = 0; cyc(2);
    chk("R6 empty again", {4'h0, iir_code}, 8'h02);
    write_ier(3'b011); write_fcr(2'b00);
    rx_count = 1; cyc(2);
    chk("R6 lowest rank", {4'h0, iir_code}, 8'h04);
    iir_rd = 1; cyc(1); iir_rd = 0;
    rx_count = 0; cyc(2);
    chk("R8 foreign read keeps", {4'h0, iir_code}, 8'h02);
    iir_rd = 1; cyc(1); iir_rd = 0; cyc(1);
    chk("R8 own read clears", {4'h0, iir_code}, 8'h01);
  endtask

  task automatic t_polled;
    write_ier(3'b000); cyc(2);
    tx_count = 4; cyc(2);
    tx_count = 0; rx_count = 16; rx_timeout = 1; rx_err = 4'b1010;
    cyc(1); rx_err = 0; cyc(2);
    chk("R9 code idle", {4'h0, iir_code}, 8'h01);
    chk("R9 irq low", {7'h0, irq}, 8'h00);
    chk("R10 ready/empty", {6'h0, lsr_rx_ready, lsr_tx_empty}, 8'h03);
    chk("R11 polled errors", {4'h0, lsr_err}, 8'h0a);
    rx_count = 0; tx_count = 2; rx_timeout = 0; cyc(1);
    chk("R10 one cycle later", {6'h0, lsr_rx_ready, lsr_tx_empty}, 8'h00);
    lsr_rd = 1; cyc(1); lsr_rd = 0;
    chk("R11 polled clear", {4'h0, lsr_err}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 0;
    cyc(1);
    t_reset();
    t_threshold();
    t_line_status();
    t_timeout();
    t_thre();
    t_polled();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule